// File: doc/BRIEF.md
# Windowed Watchdog with Two-Step Service

This block is a down-counting watchdog that software keeps alive with an ordered pair of commands. The first command arms the service. The second command completes it, but only once the count has fallen below a window threshold. A completed service reloads the counter, which closes the window again. If the counter reaches zero before a completed service, the block records an expiry, reloads, and asks for a new arming command.

Commands and status use a plain write/read register bus with no stream traffic, so there is no valid/ready handshake. A command write takes effect on the clock edge that captures it. The flag register is read combinationally. Four sticky error flags record how a service failed: a wrong arming command, a wrong completing command, a completion sent too early, or expiry. A summary bit rises with any of them and drives the interrupt pin. Writing a one to the summary bit clears it and all four error flags together; no error flag can be cleared on its own.

The reload value, the window threshold and the counter width are parameters.

Top module: `win_watchdog`

## Requirements
- R1: After reset the flag register reads 0x02 (only arm-ready set), `irq` is 0, and the counter holds `LOAD`.
- R2: Address 0 is the command register and address 1 the flag register. While waiting for arming, a command write of 0x5A arms the service: bit 1 (arm-ready) drops to 0 and no error is recorded.
- R3: While bit 1 is set, a command write of any value other than 0x5A sets bit 7 (bad arm) and the block keeps waiting for arming.
- R4: Once armed, a command write of any value other than 0xA5 sets bit 6 (bad completion) and returns the block to waiting for arming.
- R5: Once armed, a 0xA5 written while the count is at or above `WIN` sets bit 5 (early completion), does not reload the counter, and returns the block to waiting for arming.
- R6: Bit 0 (complete-ready) reads 1 exactly when the block is armed and the count is below `WIN`. A 0xA5 accepted then reloads the counter to `LOAD` and returns the block to waiting for arming without any error.
- R7: When the count is 0 and no valid completion is captured on that edge, bit 4 (expired) is set, the counter reloads to `LOAD`, and the block waits for arming. A valid completion captured on that same edge wins: the counter reloads and no expiry is recorded. Expiry therefore comes `LOAD`+1 cycles after the last reload.
- R8: Bit 3 (error summary) is set whenever any of bits 7 to 4 is set, and `irq` equals bit 3.
- R9: Writing the flag register with bit 3 = 1 clears bits 7 to 3, and the other written bits are ignored. An error event on the same edge wins: its flag and the summary bit end up set, while older flags are cleared.
- R10: Bit 2 always reads 0, the command address reads 0x00, and a flag-register write with bit 3 = 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per asserted cycle |
| bus_addr | input | ADDR_W | Register address (0 command, 1 flags) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| irq | output | 1 | High while the error summary bit is set |

## Verification
Two pairs of functions can land on the same edge. The first pair is counter expiry and a completing command: the bench arms the block, waits until the count is exactly 0, and writes 0xA5 on that edge. It then expects no expiry flag, followed by a full `LOAD`+1 cycle run to the next expiry. The second pair is the error-clearing write and a fresh expiry. The bench leaves an older bad-arm flag pending, times the write-one-to-clear for the edge where the counter hits zero, and expects the bad-arm flag gone with the expiry and summary bits set.

// File: rtl/wwd_pkg.sv
package wwd_pkg;
  localparam logic [7:0] CMD_ARM      = 8'h5A;
  localparam logic [7:0] CMD_COMPLETE = 8'hA5;

  localparam int REG_CMD   = 0;
  localparam int REG_FLAGS = 1;

  // positions inside the 4-bit error vector
  localparam int E_EXPIRED = 0;
  localparam int E_EARLY   = 1;
  localparam int E_BADCMP  = 2;
  localparam int E_BADARM  = 3;
  localparam int N_ERR     = 4;

  // flag register bit positions
  localparam int F_CMP_RDY = 0;
  localparam int F_ARM_RDY = 1;
  localparam int F_SUMMARY = 3;

  typedef enum logic {
    PH_WAIT_ARM = 1'b0,
    PH_WAIT_CMP = 1'b1
  } phase_e;
endpackage

// File: rtl/wwd_counter.sv
module wwd_counter #(
  parameter int CNT_W = 16,
  parameter int LOAD  = 1000,
  parameter int WIN   = 250
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload,
  output logic [CNT_W-1:0] cnt,
  output logic             expire,
  output logic             win_open
);
  localparam logic [CNT_W-1:0] LOAD_V = LOAD[CNT_W-1:0];
  localparam logic [CNT_W-1:0] WIN_V  = WIN[CNT_W-1:0];

  logic [CNT_W-1:0] cnt_q;
  logic             at_zero;

  assign at_zero  = (cnt_q == '0);
  assign expire   = at_zero && !reload;
  assign win_open = (cnt_q < WIN_V);
  assign cnt      = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= LOAD_V;
    end else if (reload || at_zero) begin
      cnt_q <= LOAD_V;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/wwd_sequencer.sv
module wwd_sequencer
  import wwd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_data,
  input  logic              win_open,
  input  logic              expire,
  output phase_e            phase,
  output logic              reload,
  output logic [N_ERR-1:0]  err_ev
);
  phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    reload  = 1'b0;
    err_ev  = '0;
    if (cmd_valid) begin
      unique case (phase_q)
        PH_WAIT_ARM: begin
          if (cmd_data == CMD_ARM) phase_d = PH_WAIT_CMP;
          else                     err_ev[E_BADARM] = 1'b1;
        end
        PH_WAIT_CMP: begin
          phase_d = PH_WAIT_ARM;
          if (cmd_data != CMD_COMPLETE) err_ev[E_BADCMP] = 1'b1;
          else if (win_open)            reload = 1'b1;
          else                          err_ev[E_EARLY] = 1'b1;
        end
        default: phase_d = PH_WAIT_ARM;
      endcase
    end
    if (expire) begin
      err_ev[E_EXPIRED] = 1'b1;
      phase_d           = PH_WAIT_ARM;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_WAIT_ARM;
    else        phase_q <= phase_d;
  end

  assign phase = phase_q;
endmodule

// File: rtl/wwd_flags.sv
module wwd_flags
  import wwd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_ERR-1:0] err_ev,
  input  logic             w1c,
  output logic [N_ERR-1:0] err,
  output logic             summary
);
  logic [N_ERR-1:0] err_q;
  logic             sum_q;
  logic [N_ERR-1:0] err_keep;
  logic             sum_keep;

  assign err_keep = w1c ? '0   : err_q;
  assign sum_keep = w1c ? 1'b0 : sum_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= '0;
      sum_q <= 1'b0;
    end else begin
      err_q <= err_keep | err_ev;
      sum_q <= sum_keep | (|err_ev);
    end
  end

  assign err     = err_q;
  assign summary = sum_q;
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
  import wwd_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int LOAD   = 1000,
  parameter int WIN    = 250,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(REG_CMD);
  localparam logic [ADDR_W-1:0] A_FLAGS = ADDR_W'(REG_FLAGS);

  logic             cmd_valid;
  logic             w1c;
  logic             reload;
  logic             expire;
  logic             win_open;
  logic [CNT_W-1:0] cnt_q;
  phase_e           phase;
  logic [N_ERR-1:0] err_ev;
  logic [N_ERR-1:0] err;
  logic             summary;
  logic             arm_rdy;
  logic             cmp_rdy;
  logic [7:0]       flag_byte;

  assign cmd_valid = bus_wr && (bus_addr == A_CMD);
  assign w1c       = bus_wr && (bus_addr == A_FLAGS) && bus_wdata[F_SUMMARY];

  wwd_counter #(.CNT_W(CNT_W), .LOAD(LOAD), .WIN(WIN)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .reload   (reload),
    .cnt      (cnt_q),
    .expire   (expire),
    .win_open (win_open)
  );

  wwd_sequencer u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_data  (bus_wdata),
    .win_open  (win_open),
    .expire    (expire),
    .phase     (phase),
    .reload    (reload),
    .err_ev    (err_ev)
  );

  wwd_flags u_flg (
    .clk     (clk),
    .rst_n   (rst_n),
    .err_ev  (err_ev),
    .w1c     (w1c),
    .err     (err),
    .summary (summary)
  );

  assign arm_rdy   = (phase == PH_WAIT_ARM);
  assign cmp_rdy   = (phase == PH_WAIT_CMP) && win_open;
  assign flag_byte = {err[E_BADARM], err[E_BADCMP], err[E_EARLY], err[E_EXPIRED],
                      summary, 1'b0, arm_rdy, cmp_rdy};

  always_comb begin
    if (bus_addr == A_FLAGS) bus_rdata = flag_byte;
    else                     bus_rdata = 8'h00;
  end

  assign irq = summary;
endmodule

// File: rtl/wwd_checker.sv
module wwd_checker
  import wwd_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int LOAD   = 1000,
  parameter int WIN    = 250,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              irq,
  input logic [CNT_W-1:0]  cnt,
  input logic [7:0]        flags
);
  localparam logic [CNT_W-1:0]  LOAD_V  = LOAD[CNT_W-1:0];
  localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(REG_CMD);
  localparam logic [ADDR_W-1:0] A_FLAGS = ADDR_W'(REG_FLAGS);

  logic cmd_wr;
  logic good_cmp;
  logic clr_wr;
  assign cmd_wr   = bus_wr && (bus_addr == A_CMD);
  assign good_cmp = cmd_wr && (bus_wdata == CMD_COMPLETE) && flags[F_CMP_RDY];
  assign clr_wr   = bus_wr && (bus_addr == A_FLAGS) && bus_wdata[F_SUMMARY];

  AST_BADARM_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && flags[F_ARM_RDY] && (bus_wdata != CMD_ARM)) |=> flags[7]); // R3

  AST_EARLY_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && (bus_wdata == CMD_COMPLETE) && !flags[F_ARM_RDY] && !flags[F_CMP_RDY])
      |=> (flags[5] && cnt == $past(cnt) - 1'b1)); // R5

  AST_READY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flags[1:0])); // R6

  AST_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt == '0) && !good_cmp) |=> (flags[4] && cnt == LOAD_V)); // R7

  AST_GOOD_CMP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    good_cmp |=> (cnt == LOAD_V && flags[F_ARM_RDY])); // R6

  AST_SUMMARY_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    (|flags[7:4]) |-> flags[F_SUMMARY]); // R8

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    irq == flags[F_SUMMARY]); // R8

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && cnt != '0) |=> (flags[7:3] == 5'b0)); // R9

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[2] == 1'b0); // R10
endmodule

bind win_watchdog wwd_checker #(
  .CNT_W(CNT_W), .LOAD(LOAD), .WIN(WIN), .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .cnt       (cnt_q),
  .flags     (flag_byte)
);

// File: tb/win_watchdog_tb.sv
module win_watchdog_tb;
  localparam int CNT_W  = 8;
  localparam int LOAD   = 30;
  localparam int WIN    = 10;
  localparam int ADDR_W = 2;
  localparam logic [1:0] AC = 2'd0;
  localparam logic [1:0] AF = 2'd1;
  localparam int NV = 14;

  // {gap[5:0], addr[1:0], data[7:0], exp_flags[7:0], exp_irq}
  localparam logic [24:0] VEC [NV] = '{
    {6'd0,  AC, 8'h5A, 8'h00, 1'b0},
    {6'd20, AC, 8'hA5, 8'h02, 1'b0},
    {6'd2,  AC, 8'h5A, 8'h00, 1'b0},
    {6'd2,  AC, 8'hA5, 8'h2A, 1'b1},
    {6'd0,  AF, 8'h08, 8'h02, 1'b0},
    {6'd0,  AC, 8'h33, 8'h8A, 1'b1},
    {6'd0,  AF, 8'h08, 8'h02, 1'b0},
    {6'd0,  AC, 8'h5A, 8'h00, 1'b0},
    {6'd0,  AC, 8'h5A, 8'h4A, 1'b1},
    {6'd0,  AF, 8'h08, 8'h02, 1'b0},
    {6'd0,  AC, 8'h5A, 8'h00, 1'b0},
    {6'd7,  AF, 8'hF7, 8'h01, 1'b0},
    {6'd0,  AC, 8'hA5, 8'h02, 1'b0},
    {6'd0,  AC, 8'h5A, 8'h00, 1'b0}
  };

  function automatic string vtag(int i);
    case (i)
      0, 2, 7, 10, 13: return "R2";
      1, 12:           return "R6";
      3:               return "R5";
      4, 6, 9:         return "R9";
      5:               return "R3";
      8:               return "R4";
      default:         return "R10";
    endcase
  endfunction

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = AF;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic        irq;
  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  win_watchdog #(.CNT_W(CNT_W), .LOAD(LOAD), .WIN(WIN), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      failures = failures + 1;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(string tag, logic [7:0] exp_f, logic exp_i);
    checks = checks + 1;
    if (bus_rdata !== exp_f || irq !== exp_i) begin
      failures = failures + 1;
      $display("FAIL %s flags=%02h irq=%0b expected flags=%02h irq=%0b",
               tag, bus_rdata, irq, exp_f, exp_i);
    end
  endtask

  // called just after a falling edge; one rising edge captures the write
  task automatic wr(logic [1:0] a, logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = AF;
    #1;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1", 8'h02, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    // the rising edge just passed took the count to LOAD-1; realign below
    rst_n = 1'b0; #1; rst_n = 1'b1;
    check("R1", 8'h02, 1'b0);

    for (int i = 0; i < NV; i++) begin
      idle(int'(VEC[i][24:19]));
      wr(VEC[i][18:17], VEC[i][16:9]);
      check(vtag(i), VEC[i][8:1], VEC[i][0]);
    end

    // armed, count 29: run to zero, window open at the last count
    idle(29);
    check("R6", 8'h01, 1'b0);
    idle(1);
    check("R7", 8'h1A, 1'b1);
    check("R8", 8'h1A, 1'b1);

    // clear write lands on the expiry edge while an older flag is pending
    wr(AF, 8'h08);
    check("R9", 8'h02, 1'b0);
    wr(AC, 8'h00);
    check("R3", 8'h8A, 1'b1);
    idle(28);
    wr(AF, 8'h08);
    check("R9", 8'h1A, 1'b1);

    // completion captured on the final count beats expiry
    wr(AF, 8'h08);
    wr(AC, 8'h5A);
    idle(28);
    wr(AC, 8'hA5);
    check("R7", 8'h02, 1'b0);
    idle(30);
    check("R7", 8'h02, 1'b0);
    idle(1);
    check("R7", 8'h1A, 1'b1);

    // command address reads zero
    bus_addr = AC; #1;
    check("R10", 8'h00, 1'b1);
    bus_addr = AF; #1;

    // reset in mid-run
    @(negedge clk);
    rst_n = 1'b0; #1;
    check("R1", 8'h02, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule